// File: doc/BRIEF.md
# Host/Core Mailbox Engine with Packed Status

This block moves 32-bit words between a host and a compute core through three small queues. Two queues carry data outward to the host: a general outbound mailbox and an interrupt mailbox, each holding a single word. The third is an inbound queue from the host to the core, four words deep. The core fills the outbound mailboxes and drains the inbound queue through simple push and pop ports. The host reads the outbound mailboxes, writes the inbound queue and polls for readiness.

A packed status word reports the state of all three queues at once. For the two outbound mailboxes it gives the number of words held. For the inbound queue it gives the number of free slots, not the number of words held. Every host access returns a byte count: a full word on success, zero when it fails. A successful access also sends a single-cycle event strobe to the core. When a host access fails, it arms the interrupt enable that matches the missing condition, so that a later change of state can wake the host.

Each mailbox has a core-side "channel available" flag. It tells the core whether it may push again.

Top module: `mbx_status_top`

## Requirements
- R1: `statusWord` bits [7:0] give the outbound word count (0 or 1). Bits [15:8] give the inbound free-slot count (0 to 4). Bits [23:16] give the interrupt-mailbox word count (0 or 1). After reset the word is 0x000400, and both channel-available flags are 1.
- R2: A host outbound read that finds a word returns it on `hostRdData` with `rdXferBytes`=4, one cycle after the request. In that same cycle the outbound count becomes 0, `outChanAvail` becomes 1 and `evtOutRead` pulses. A host outbound read that finds no word gives `rdXferBytes`=0 and no event. If both reads are requested in one cycle, only the outbound read is carried out.
- R3: A host interrupt-mailbox read behaves as in R2, but uses its own count field, `intChanAvail` and `evtIntRead`. When the interrupt mailbox is empty, the read sets `intEnMbox`.
- R4: A host inbound write with free space stores the word behind the words already queued and lowers the free count by one. It reports `wrXferBytes`=4 and pulses `evtInWritten`.
- R5: A host inbound write that finds 0 free slots is rejected. It gives `wrXferBytes`=0 and no event, leaves the queue unchanged and sets `intEnThresh`.
- R6: A core pop returns inbound words in first-in first-out order on `coreInData`, and raises the free count by one. A write and a pop in the same cycle leave the free count unchanged.
- R7: A core push into an outbound or interrupt mailbox that already holds a word is ignored, and the stored word is kept. An accepted push clears that mailbox's channel-available flag.
- R8: `intStatMbox` is set when the core pushes a word into the interrupt mailbox. `intStatThresh` is set when a core pop frees a slot in a full inbound queue. `irqMbox` and `irqThresh` are each the pending bit ANDed with its enable.
- R9: On a poll, read interest with an empty interrupt mailbox clears `intStatMbox` and sets `intEnMbox`. Write interest with 0 free slots clears `intStatThresh` and sets `intEnThresh`. The cycle after a poll, `pollReadable` and `pollWritable` report a nonzero interrupt-mailbox count and a nonzero free count.
- R10: `errFlag` sets if the free count ever differs from 4 minus the inbound fill. It then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostOutRd | input | 1 | Host read of outbound mailbox |
| hostIntRd | input | 1 | Host read of interrupt mailbox |
| hostInWr | input | 1 | Host write to inbound queue |
| hostWrData | input | 32 | Host write word |
| pollReq | input | 1 | Host poll request |
| pollWantRd | input | 1 | Poll asks for read readiness |
| pollWantWr | input | 1 | Poll asks for write readiness |
| coreOutPush | input | 1 | Core push into outbound mailbox |
| coreOutData | input | 32 | Core outbound word |
| coreIntPush | input | 1 | Core push into interrupt mailbox |
| coreIntData | input | 32 | Core interrupt word |
| coreInPop | input | 1 | Core pop of inbound queue |
| coreInData | output | 32 | Head of inbound queue |
| coreInValid | output | 1 | Inbound queue holds a word |
| hostRdData | output | 32 | Word returned by host read |
| rdXferBytes | output | 3 | Bytes moved by last read (4 or 0) |
| wrXferBytes | output | 3 | Bytes moved by last write (4 or 0) |
| evtOutRead | output | 1 | Outbound mailbox read event |
| evtIntRead | output | 1 | Interrupt mailbox read event |
| evtInWritten | output | 1 | Inbound mailbox written event |
| outChanAvail | output | 1 | Core may push outbound |
| intChanAvail | output | 1 | Core may push interrupt word |
| statusWord | output | 24 | Packed queue status |
| pollReadable | output | 1 | Poll result: interrupt word present |
| pollWritable | output | 1 | Poll result: inbound space present |
| intStatMbox | output | 1 | Pending mailbox interrupt |
| intStatThresh | output | 1 | Pending threshold interrupt |
| intEnMbox | output | 1 | Mailbox interrupt enable |
| intEnThresh | output | 1 | Threshold interrupt enable |
| irqMbox | output | 1 | Mailbox interrupt request |
| irqThresh | output | 1 | Threshold interrupt request |
| errFlag | output | 1 | Sticky free/fill mismatch |

## Verification
Both outbound mailboxes are read while empty and while full. This shows that the byte count and the event follow the count field, and that an empty interrupt read arms its enable. The inbound queue is filled one write at a time, from 4 free slots down to 0, and a fifth write is tried. This separates the slot-placement and free-count arithmetic from the rejection path. Drain patterns check first-in first-out order: pops alone, and a write issued in the same cycle as a pop. Polls are issued with and without the awaited condition, to tell the clear-and-arm path apart from a plain readiness report.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // Strobes from control to datapath, one per state change.
  typedef struct packed {
    logic outLoad;
    logic outPop;
    logic intLoad;
    logic intPop;
    logic inPush;
    logic inPop;
  } mbxStrb_t;
endpackage

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int IN_DEPTH = 4,
  parameter int FIELD_W  = 8,
  parameter int FILL_W   = $clog2(IN_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mbxStrb_t             strb,
  input  logic [DATA_W-1:0]    hostWrData,
  input  logic [DATA_W-1:0]    coreOutData,
  input  logic [DATA_W-1:0]    coreIntData,
  output logic                 outCnt,
  output logic                 intCnt,
  output logic [FILL_W-1:0]    inFill,
  output logic [FILL_W-1:0]    inFree,
  output logic [DATA_W-1:0]    outWord,
  output logic [DATA_W-1:0]    intWord,
  output logic [DATA_W-1:0]    inHead,
  output logic [3*FIELD_W-1:0] statusWord,
  output logic                 errFlag
);
  localparam logic [FILL_W-1:0] DEPTH_V = FILL_W'(IN_DEPTH);
  localparam logic [FILL_W-1:0] ONE_V   = FILL_W'(1);

  logic [DATA_W-1:0] inQ [IN_DEPTH];
  logic [FILL_W-1:0] slotTgt;

  // On a write, the new word goes into the slot just past the last queued word.
  // If a pop happens in the same cycle, the queue shifts down, so that slot is one lower.
  assign slotTgt = strb.inPop ? (inFill - ONE_V) : inFill;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outCnt  <= 1'b0;
      intCnt  <= 1'b0;
      outWord <= '0;
      intWord <= '0;
    end else begin
      if (strb.outLoad) begin
        outCnt  <= 1'b1;
        outWord <= coreOutData;
      end else if (strb.outPop) begin
        outCnt <= 1'b0;
      end
      if (strb.intLoad) begin
        intCnt  <= 1'b1;
        intWord <= coreIntData;
      end else if (strb.intPop) begin
        intCnt <= 1'b0;
      end
    end
  end

  // Fill and free are kept as separate registers so that a mismatch between them can be detected.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFill <= '0;
      inFree <= DEPTH_V;
    end else begin
      case ({strb.inPush, strb.inPop})
        2'b10: begin
          inFill <= inFill + ONE_V;
          inFree <= inFree - ONE_V;
        end
        2'b01: begin
          inFill <= inFill - ONE_V;
          inFree <= inFree + ONE_V;
        end
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < IN_DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        inQ[i] <= '0;
      end else begin
        if (strb.inPop) begin
          if (i < IN_DEPTH - 1) inQ[i] <= inQ[(i < IN_DEPTH - 1) ? i + 1 : i];
        end
        if (strb.inPush && slotTgt == FILL_W'(i)) inQ[i] <= hostWrData;
      end
    end
  end

  assign inHead = inQ[0];

  assign statusWord = {{(FIELD_W-1){1'b0}}, intCnt,
                       {(FIELD_W-FILL_W){1'b0}}, inFree,
                       {(FIELD_W-1){1'b0}}, outCnt};

  always_ff @(posedge clk) begin
    if (!rstN) errFlag <= 1'b0;
    else if (inFree != DEPTH_V - inFill) errFlag <= 1'b1;
  end

  // R5: control must never push when no slot is free
  a_r5_no_push_full: assert property (@(posedge clk) disable iff (!rstN)
    strb.inPush |-> inFree != '0);
  // R4: an accepted write without a pop lowers free by one
  a_r4_free_drop: assert property (@(posedge clk) disable iff (!rstN)
    (strb.inPush && !strb.inPop) |=> inFree == $past(inFree) - ONE_V);
  // R6: a pop without a write lowers fill by one
  a_r6_fill_drop: assert property (@(posedge clk) disable iff (!rstN)
    (strb.inPop && !strb.inPush) |=> inFill == $past(inFill) - ONE_V);
  // R10: free and fill stay complementary
  a_r10_free_fill: assert property (@(posedge clk) disable iff (!rstN)
    inFree + inFill == DEPTH_V);
  // R7: a load never replaces a held outbound word
  a_r7_no_overwrite: assert property (@(posedge clk) disable iff (!rstN)
    (outCnt && !strb.outPop) |=> $stable(outWord));
endmodule

// File: rtl/mbx_control.sv
module mbx_control
  import mbx_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int IN_DEPTH = 4,
  parameter int FILL_W   = $clog2(IN_DEPTH + 1),
  parameter int XW       = $clog2(DATA_W / 8 + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostOutRd,
  input  logic              hostIntRd,
  input  logic              hostInWr,
  input  logic              pollReq,
  input  logic              pollWantRd,
  input  logic              pollWantWr,
  input  logic              coreOutPush,
  input  logic              coreIntPush,
  input  logic              coreInPop,
  input  logic              outCnt,
  input  logic              intCnt,
  input  logic [FILL_W-1:0] inFill,
  input  logic [FILL_W-1:0] inFree,
  input  logic [DATA_W-1:0] outWord,
  input  logic [DATA_W-1:0] intWord,
  output mbxStrb_t          strb,
  output logic [DATA_W-1:0] hostRdData,
  output logic [XW-1:0]     rdXferBytes,
  output logic [XW-1:0]     wrXferBytes,
  output logic              evtOutRead,
  output logic              evtIntRead,
  output logic              evtInWritten,
  output logic              outChanAvail,
  output logic              intChanAvail,
  output logic              pollReadable,
  output logic              pollWritable,
  output logic              intStatMbox,
  output logic              intStatThresh,
  output logic              intEnMbox,
  output logic              intEnThresh,
  output logic              irqMbox,
  output logic              irqThresh
);
  localparam logic [XW-1:0] FULL_XFER = XW'(DATA_W / 8);

  logic intRdReq, outRdOk, intRdOk, outRdMiss, intRdMiss, inWrOk, inWrMiss;
  logic pollRdMiss, pollWrMiss, popFromFull;

  // The outbound read has priority: when both reads are requested together, the interrupt read is dropped.
  assign intRdReq  = hostIntRd && !hostOutRd;
  assign outRdOk   = hostOutRd && outCnt;
  assign outRdMiss = hostOutRd && !outCnt;
  assign intRdOk   = intRdReq && intCnt;
  assign intRdMiss = intRdReq && !intCnt;
  assign inWrOk    = hostInWr && (inFree != '0);
  assign inWrMiss  = hostInWr && (inFree == '0);
  assign pollRdMiss = pollReq && pollWantRd && !intCnt;
  assign pollWrMiss = pollReq && pollWantWr && (inFree == '0);
  assign popFromFull = strb.inPop && (inFree == '0);

  always_comb begin
    strb         = '0;
    strb.outPop  = outRdOk;
    strb.intPop  = intRdOk;
    strb.outLoad = coreOutPush && !outCnt;
    strb.intLoad = coreIntPush && !intCnt;
    strb.inPush  = inWrOk;
    strb.inPop   = coreInPop && (inFill != '0);
  end

  // Host responses and event strobes, registered one cycle after the request.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRdData   <= '0;
      rdXferBytes  <= '0;
      wrXferBytes  <= '0;
      evtOutRead   <= 1'b0;
      evtIntRead   <= 1'b0;
      evtInWritten <= 1'b0;
      pollReadable <= 1'b0;
      pollWritable <= 1'b0;
    end else begin
      evtOutRead   <= outRdOk;
      evtIntRead   <= intRdOk;
      evtInWritten <= inWrOk;
      rdXferBytes  <= (outRdOk || intRdOk) ? FULL_XFER : '0;
      wrXferBytes  <= inWrOk ? FULL_XFER : '0;
      if (outRdOk)      hostRdData <= outWord;
      else if (intRdOk) hostRdData <= intWord;
      pollReadable <= pollReq && intCnt;
      pollWritable <= pollReq && (inFree != '0);
    end
  end

  // Core-side channel-available flags.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outChanAvail <= 1'b1;
      intChanAvail <= 1'b1;
    end else begin
      if (outRdOk)           outChanAvail <= 1'b1;
      else if (strb.outLoad) outChanAvail <= 1'b0;
      if (intRdOk)           intChanAvail <= 1'b1;
      else if (strb.intLoad) intChanAvail <= 1'b0;
    end
  end

  // Pending bits and enables. When a pending bit is set and cleared in the same cycle, the new set wins.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      intStatMbox   <= 1'b0;
      intStatThresh <= 1'b0;
      intEnMbox     <= 1'b0;
      intEnThresh   <= 1'b0;
    end else begin
      if (strb.intLoad)   intStatMbox <= 1'b1;
      else if (pollRdMiss) intStatMbox <= 1'b0;
      if (popFromFull)     intStatThresh <= 1'b1;
      else if (pollWrMiss) intStatThresh <= 1'b0;
      if (intRdMiss || pollRdMiss) intEnMbox   <= 1'b1;
      if (inWrMiss || pollWrMiss)  intEnThresh <= 1'b1;
    end
  end

  assign irqMbox   = intStatMbox && intEnMbox;
  assign irqThresh = intStatThresh && intEnThresh;

  // R2: the read byte count is either zero or a full word
  a_r2_xfer_legal: assert property (@(posedge clk) disable iff (!rstN)
    rdXferBytes == '0 || rdXferBytes == FULL_XFER);
  // R2: an empty outbound read reports nothing and raises no event
  a_r2_empty_read: assert property (@(posedge clk) disable iff (!rstN)
    (hostOutRd && !outCnt) |=> (rdXferBytes == '0 && !evtOutRead));
  // R3: an empty interrupt-mailbox read arms the mailbox enable
  a_r3_empty_arms: assert property (@(posedge clk) disable iff (!rstN)
    (hostIntRd && !hostOutRd && !intCnt) |=> intEnMbox);
  // R5: a write into a full queue arms the threshold enable and moves nothing
  a_r5_full_reject: assert property (@(posedge clk) disable iff (!rstN)
    (hostInWr && inFree == '0) |=> (intEnThresh && wrXferBytes == '0 && !evtInWritten));
  // R9: a write-interest poll with no space clears the pending threshold bit
  a_r9_poll_clear: assert property (@(posedge clk) disable iff (!rstN)
    (pollReq && pollWantWr && inFree == '0 && !coreInPop) |=> !intStatThresh);
endmodule

// File: rtl/mbx_status_top.sv
module mbx_status_top
  import mbx_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int IN_DEPTH = 4,
  parameter int FIELD_W  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostOutRd,
  input  logic                 hostIntRd,
  input  logic                 hostInWr,
  input  logic [DATA_W-1:0]    hostWrData,
  input  logic                 pollReq,
  input  logic                 pollWantRd,
  input  logic                 pollWantWr,
  input  logic                 coreOutPush,
  input  logic [DATA_W-1:0]    coreOutData,
  input  logic                 coreIntPush,
  input  logic [DATA_W-1:0]    coreIntData,
  input  logic                 coreInPop,
  output logic [DATA_W-1:0]    coreInData,
  output logic                 coreInValid,
  output logic [DATA_W-1:0]    hostRdData,
  output logic [$clog2(DATA_W/8+1)-1:0] rdXferBytes,
  output logic [$clog2(DATA_W/8+1)-1:0] wrXferBytes,
  output logic                 evtOutRead,
  output logic                 evtIntRead,
  output logic                 evtInWritten,
  output logic                 outChanAvail,
  output logic                 intChanAvail,
  output logic [3*FIELD_W-1:0] statusWord,
  output logic                 pollReadable,
  output logic                 pollWritable,
  output logic                 intStatMbox,
  output logic                 intStatThresh,
  output logic                 intEnMbox,
  output logic                 intEnThresh,
  output logic                 irqMbox,
  output logic                 irqThresh,
  output logic                 errFlag
);
  localparam int FILL_W = $clog2(IN_DEPTH + 1);
  localparam int XW     = $clog2(DATA_W / 8 + 1);

  mbxStrb_t          strb;
  logic              outCnt, intCnt;
  logic [FILL_W-1:0] inFill, inFree;
  logic [DATA_W-1:0] outWord, intWord;

  assign coreInValid = (inFill != '0);

  mbx_control #(.DATA_W(DATA_W), .IN_DEPTH(IN_DEPTH), .FILL_W(FILL_W), .XW(XW)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .hostOutRd(hostOutRd), .hostIntRd(hostIntRd), .hostInWr(hostInWr),
    .pollReq(pollReq), .pollWantRd(pollWantRd), .pollWantWr(pollWantWr),
    .coreOutPush(coreOutPush), .coreIntPush(coreIntPush), .coreInPop(coreInPop),
    .outCnt(outCnt), .intCnt(intCnt), .inFill(inFill), .inFree(inFree),
    .outWord(outWord), .intWord(intWord), .strb(strb),
    .hostRdData(hostRdData), .rdXferBytes(rdXferBytes), .wrXferBytes(wrXferBytes),
    .evtOutRead(evtOutRead), .evtIntRead(evtIntRead), .evtInWritten(evtInWritten),
    .outChanAvail(outChanAvail), .intChanAvail(intChanAvail),
    .pollReadable(pollReadable), .pollWritable(pollWritable),
    .intStatMbox(intStatMbox), .intStatThresh(intStatThresh),
    .intEnMbox(intEnMbox), .intEnThresh(intEnThresh),
    .irqMbox(irqMbox), .irqThresh(irqThresh)
  );

  mbx_datapath #(.DATA_W(DATA_W), .IN_DEPTH(IN_DEPTH), .FIELD_W(FIELD_W), .FILL_W(FILL_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .hostWrData(hostWrData), .coreOutData(coreOutData), .coreIntData(coreIntData),
    .outCnt(outCnt), .intCnt(intCnt), .inFill(inFill), .inFree(inFree),
    .outWord(outWord), .intWord(intWord), .inHead(coreInData),
    .statusWord(statusWord), .errFlag(errFlag)
  );
endmodule

// File: tb/mbx_status_top_tb.sv
module mbx_status_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostOutRd = 0, hostIntRd = 0, hostInWr = 0, pollReq = 0, pollWantRd = 0, pollWantWr = 0;
  logic coreOutPush = 0, coreIntPush = 0, coreInPop = 0;
  logic [31:0] hostWrData = '0, coreOutData = '0, coreIntData = '0;
  logic [31:0] coreInData, hostRdData;
  logic coreInValid;
  logic [2:0] rdXferBytes, wrXferBytes;
  logic evtOutRead, evtIntRead, evtInWritten, outChanAvail, intChanAvail;
  logic [23:0] statusWord;
  logic pollReadable, pollWritable, intStatMbox, intStatThresh, intEnMbox, intEnThresh;
  logic irqMbox, irqThresh, errFlag;

  int nChecks = 0;
  int nFails  = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mbx_status_top dut_i (
    .clk(clk), .rstN(rstN), .hostOutRd(hostOutRd), .hostIntRd(hostIntRd), .hostInWr(hostInWr),
    .hostWrData(hostWrData), .pollReq(pollReq), .pollWantRd(pollWantRd), .pollWantWr(pollWantWr),
    .coreOutPush(coreOutPush), .coreOutData(coreOutData), .coreIntPush(coreIntPush),
    .coreIntData(coreIntData), .coreInPop(coreInPop), .coreInData(coreInData),
    .coreInValid(coreInValid), .hostRdData(hostRdData), .rdXferBytes(rdXferBytes),
    .wrXferBytes(wrXferBytes), .evtOutRead(evtOutRead), .evtIntRead(evtIntRead),
    .evtInWritten(evtInWritten), .outChanAvail(outChanAvail), .intChanAvail(intChanAvail),
    .statusWord(statusWord), .pollReadable(pollReadable), .pollWritable(pollWritable),
    .intStatMbox(intStatMbox), .intStatThresh(intStatThresh), .intEnMbox(intEnMbox),
    .intEnThresh(intEnThresh), .irqMbox(irqMbox), .irqThresh(irqThresh), .errFlag(errFlag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Runs one clock edge with the inputs already driven, then clears all strobes at the following negedge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    hostOutRd = 0; hostIntRd = 0; hostInWr = 0; pollReq = 0; pollWantRd = 0; pollWantWr = 0;
    coreOutPush = 0; coreIntPush = 0; coreInPop = 0;
  endtask

  task automatic t_reset();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 reset status", 32'(statusWord), 32'h000400);
    chk("R1 reset outChanAvail", 32'(outChanAvail), 1);
    chk("R1 reset intChanAvail", 32'(intChanAvail), 1);
    chk("R1 reset enables", 32'({intEnMbox, intEnThresh, irqMbox, irqThresh}), 0);
  endtask

  task automatic t_outbound();
    hostOutRd = 1; step();
    chk("R2 empty read xfer", 32'(rdXferBytes), 0);
    chk("R2 empty read event", 32'(evtOutRead), 0);
    coreOutData = 32'hA0A0_0001; coreOutPush = 1; step();
    chk("R1 out count field", 32'(statusWord[7:0]), 1);
    chk("R7 chan avail cleared", 32'(outChanAvail), 0);
    coreOutData = 32'hBEEF_0002; coreOutPush = 1; step();
    hostOutRd = 1; step();
    chk("R7 kept first word", hostRdData, 32'hA0A0_0001);
    chk("R2 read xfer", 32'(rdXferBytes), 4);
    chk("R2 read event", 32'(evtOutRead), 1);
    chk("R2 count cleared", 32'(statusWord[7:0]), 0);
    chk("R2 chan avail set", 32'(outChanAvail), 1);
    step();
    chk("R2 event single pulse", 32'(evtOutRead), 0);
  endtask

  task automatic t_intmbox();
    hostIntRd = 1; step();
    chk("R3 empty read xfer", 32'(rdXferBytes), 0);
    chk("R3 empty read arms enable", 32'(intEnMbox), 1);
    coreIntData = 32'hC0DE_0003; coreIntPush = 1; step();
    chk("R1 int count field", 32'(statusWord[23:16]), 1);
    chk("R8 pending on push", 32'(intStatMbox), 1);
    chk("R8 irq raised", 32'(irqMbox), 1);
    pollReq = 1; pollWantRd = 1; step();
    chk("R9 poll readable", 32'(pollReadable), 1);
    chk("R9 pending kept when present", 32'(intStatMbox), 1);
    hostIntRd = 1; hostOutRd = 1; step();
    chk("R2 priority: int read skipped", 32'(statusWord[23:16]), 1);
    hostIntRd = 1; step();
    chk("R3 read word", hostRdData, 32'hC0DE_0003);
    chk("R3 read xfer", 32'(rdXferBytes), 4);
    chk("R3 read event", 32'(evtIntRead), 1);
    chk("R3 count cleared", 32'(statusWord[23:16]), 0);
    chk("R3 chan avail", 32'(intChanAvail), 1);
    pollReq = 1; pollWantRd = 1; step();
    chk("R9 poll not readable", 32'(pollReadable), 0);
    chk("R9 poll clears pending", 32'(intStatMbox), 0);
    chk("R8 irq dropped", 32'(irqMbox), 0);
  endtask

  task automatic t_inbound();
    for (int k = 0; k < 4; k++) begin
      hostWrData = 32'h1000 + 32'(k); hostInWr = 1; step();
      chk("R4 write xfer", 32'(wrXferBytes), 4);
      chk("R4 write event", 32'(evtInWritten), 1);
      chk("R4 free field", 32'(statusWord[15:8]), 32'(3 - k));
    end
    pollReq = 1; pollWantWr = 1; step();
    chk("R9 poll not writable", 32'(pollWritable), 0);
    chk("R9 poll arms thresh", 32'(intEnThresh), 1);
    rstN = 0; step(); rstN = 1; step();
    for (int k = 0; k < 4; k++) begin
      hostWrData = 32'h1000 + 32'(k); hostInWr = 1; step();
    end
    hostWrData = 32'hDEAD_DEAD; hostInWr = 1; step();
    chk("R5 reject xfer", 32'(wrXferBytes), 0);
    chk("R5 reject no event", 32'(evtInWritten), 0);
    chk("R5 arms thresh", 32'(intEnThresh), 1);
    chk("R5 free still zero", 32'(statusWord[15:8]), 0);
    chk("R6 head", coreInData, 32'h1000);
    coreInPop = 1; step();
    chk("R6 free after pop", 32'(statusWord[15:8]), 1);
    chk("R8 thresh pending", 32'(intStatThresh), 1);
    chk("R8 thresh irq", 32'(irqThresh), 1);
    chk("R6 head after pop", coreInData, 32'h1001);
    hostWrData = 32'h1004; hostInWr = 1; coreInPop = 1; step();
    chk("R6 free unchanged w+p", 32'(statusWord[15:8]), 1);
    for (int k = 2; k < 5; k++) begin
      chk("R6 fifo order", coreInData, 32'h1000 + 32'(k));
      coreInPop = 1; step();
    end
    chk("R6 drained", 32'(coreInValid), 0);
    chk("R5 rejected word absent", 32'(statusWord[15:8]), 4);
    pollReq = 1; pollWantWr = 1; step();
    chk("R9 poll writable", 32'(pollWritable), 1);
    chk("R9 pending kept when space", 32'(intStatThresh), 1);
    for (int k = 0; k < 4; k++) begin
      hostWrData = 32'h2000; hostInWr = 1; step();
    end
    pollReq = 1; pollWantWr = 1; step();
    chk("R9 poll clears thresh", 32'(intStatThresh), 0);
    chk("R8 thresh irq dropped", 32'(irqThresh), 0);
    chk("R10 no mismatch", 32'(errFlag), 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_outbound();
        t_intmbox();
        t_inbound();
      end
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule